// File: doc/BRIEF.md
# Two-Tier Non-Preemptive Bus Arbiter

This block decides which of four on-chip masters owns the internal bus. The masters are an external-bus DMA engine, a general DMA controller, a data-transfer controller and the CPU. Each master raises a request and receives an acknowledge. The acknowledge goes to the highest-ranked requester. Once it is given, it is never taken back by force. The owner keeps the bus until it drops its request or raises its release-ready strobe, which marks a point where it may safely hand the bus over. After every release the bus sits idle for one cycle before the next acknowledge appears.

A second, independent tier shares the external bus among four users:

- a DRAM refresh,
- an external access by the external-bus DMA engine,
- an external bus-release request,
- an external access by whichever other master currently owns the internal bus.

These users are ranked in a fixed order, and their grants are also non-preemptive. A mode input selects how refresh behaves. In shared mode, a refresh and a master access to a non-DRAM region may run at the same time. In exclusive mode, a refresh waits for the external bus to drain and then holds it alone.

Top module: `busarb_top`

## Requirements
- R1: After reset no internal acknowledge and no external grant is asserted.
- R2: When no master owns the internal bus and any request is high at a clock edge, the acknowledge of the highest-ranked requester rises after that edge. Bit order of `mreq`/`mack` is: bit 0 external-bus DMA (highest), bit 1 DMA controller, bit 2 data-transfer controller, bit 3 CPU (lowest).
- R3: At most one internal acknowledge is high in any cycle.
- R4: While the owner keeps its request high and its release strobe low, its acknowledge stays high, whatever the other masters request.
- R5: When the owner's request is low or its release strobe is high at an edge, its acknowledge falls after that edge, and all acknowledges stay low for that next cycle.
- R6: External grants rank refresh above external-bus DMA, that above bus release, and that above a master external access. A waiting higher-ranked request prevents any lower-ranked request from starting.
- R7: At most one external grant is high, except that refresh and master access may both be high when `rfsh_excl` is 0 and `mst_xdram` is 0.
- R8: With `rfsh_excl` 0, a refresh is granted while a non-DRAM master access is in progress, and a non-DRAM master access is granted while a refresh is in progress, unless a higher-ranked request is waiting.
- R9: With `rfsh_excl` 1, a refresh is granted only once no external grant is held, and no other external grant is issued while it runs.
- R10: A master external access is granted only while one of `mack[3:1]` was high in the previous cycle.
- R11: An external grant stays high for as long as its request stays high. For the master access, this means `mst_xreq` is high and the master still owns the internal bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mreq | input | NM | Internal bus requests, bit 0 highest rank |
| mrdy | input | NM | Release-ready strobes, one per master |
| rfsh_excl | input | 1 | 1: refresh is exclusive; 0: refresh may share with non-DRAM master access |
| rfsh_req | input | 1 | DRAM refresh wants the external bus |
| xdma_xreq | input | 1 | External-bus DMA wants the external bus |
| brel_req | input | 1 | External bus-release request |
| mst_xreq | input | 1 | Current internal owner wants an external access |
| mst_xdram | input | 1 | That access targets DRAM space (held stable while `mst_xreq` is high) |
| mack | output | NM | Internal bus acknowledges |
| rfsh_gnt | output | 1 | Refresh granted |
| xdma_xgnt | output | 1 | External-bus DMA access granted |
| brel_gnt | output | 1 | Bus release granted |
| mst_xgnt | output | 1 | Master external access granted |

## Verification
The hardest case to reach is a refresh request that arrives while a lower-ranked external user already holds the bus, with a higher-ranked user also waiting. Only in that case do the shared/exclusive rules and the blocking of waiting requests interact. Random traffic reaches it only rarely, because the master access also needs an internal owner other than the DMA engine. For this reason, directed sequences first build the overlap in each mode: a master owns the internal bus, then an external grant is held, then a refresh request is added. After that, long random phases run in each mode, with requests held for random lengths, so that waiting requests pile up behind held grants.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  localparam int XK = 4;
  localparam int XK_RFSH = 0;
  localparam int XK_XDMA = 1;
  localparam int XK_BREL = 2;
  localparam int XK_MST  = 3;

  // index of the lowest set bit (highest rank); 0 if none
  function automatic int first_req(input logic [31:0] v, input int n);
    int r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // may external user k start next to the grant set already decided
  function automatic logic ext_fits(input int k, input logic [XK-1:0] cur,
                                    input logic excl, input logic dram);
    logic share;
    logic [XK-1:0] only_rf;
    logic [XK-1:0] only_ms;
    share   = !excl && !dram;
    only_rf = '0;
    only_ms = '0;
    only_rf[XK_RFSH] = 1'b1;
    only_ms[XK_MST]  = 1'b1;
    if (cur == '0) return 1'b1;
    if (k == XK_RFSH) return share && (cur == only_ms);
    if (k == XK_MST)  return share && (cur == only_rf);
    return 1'b0;
  endfunction
endpackage

// File: rtl/busarb_int.sv
module busarb_int #(
  parameter int NM = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req,
  input  logic [NM-1:0] rdy,
  output logic [NM-1:0] ack,
  output logic          rel_ev,
  output logic          start_ev
);
  import busarb_pkg::*;
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;

  logic          own_vld;
  logic [IW-1:0] own_idx;
  logic [31:0]   req_w;

  assign req_w    = 32'(req);
  assign rel_ev   = own_vld && (!req[own_idx] || rdy[own_idx]);
  assign start_ev = !own_vld && (req != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_vld <= 1'b0;
      own_idx <= '0;
    end else if (rel_ev) begin
      own_vld <= 1'b0;
    end else if (start_ev) begin
      own_vld <= 1'b1;
      own_idx <= IW'(first_req(req_w, NM));
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_ack
    assign ack[i] = own_vld && (own_idx == IW'(i));
  end
endmodule

// File: rtl/busarb_ext.sv
module busarb_ext (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [busarb_pkg::XK-1:0] xreq,
  input  logic                     excl,
  input  logic                     dram,
  output logic [busarb_pkg::XK-1:0] xgnt
);
  import busarb_pkg::*;

  logic [XK-1:0] held;
  logic [XK-1:0] nxt;
  logic          blk;

  assign held = xgnt & xreq;

  always_comb begin
    nxt = held;
    blk = 1'b0;
    for (int k = 0; k < XK; k++) begin
      if (xreq[k] && !held[k]) begin
        if (!blk && ext_fits(k, nxt, excl, dram)) nxt[k] = 1'b1;
        else blk = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) xgnt <= '0;
    else        xgnt <= nxt;
  end
endmodule

// File: rtl/busarb_top.sv
module busarb_top #(
  parameter int NM = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] mreq,
  input  logic [NM-1:0] mrdy,
  input  logic          rfsh_excl,
  input  logic          rfsh_req,
  input  logic          xdma_xreq,
  input  logic          brel_req,
  input  logic          mst_xreq,
  input  logic          mst_xdram,
  output logic [NM-1:0] mack,
  output logic          rfsh_gnt,
  output logic          xdma_xgnt,
  output logic          brel_gnt,
  output logic          mst_xgnt
);
  import busarb_pkg::*;

  logic          int_rel;
  logic          int_start;
  logic          mst_owns;
  logic [XK-1:0] xreq_eff;
  logic [XK-1:0] xgnt;

  busarb_int #(.NM(NM)) u_int (
    .clk(clk), .rst_n(rst_n), .req(mreq), .rdy(mrdy),
    .ack(mack), .rel_ev(int_rel), .start_ev(int_start)
  );

  // a non-DMA-engine master holds the internal bus
  assign mst_owns = |mack[NM-1:1];

  assign xreq_eff[XK_RFSH] = rfsh_req;
  assign xreq_eff[XK_XDMA] = xdma_xreq;
  assign xreq_eff[XK_BREL] = brel_req;
  assign xreq_eff[XK_MST]  = mst_xreq && mst_owns;

  busarb_ext u_ext (
    .clk(clk), .rst_n(rst_n), .xreq(xreq_eff),
    .excl(rfsh_excl), .dram(mst_xdram), .xgnt(xgnt)
  );

  assign rfsh_gnt  = xgnt[XK_RFSH];
  assign xdma_xgnt = xgnt[XK_XDMA];
  assign brel_gnt  = xgnt[XK_BREL];
  assign mst_xgnt  = xgnt[XK_MST];
endmodule

// File: rtl/busarb_chk.sv
module busarb_chk #(
  parameter int NM = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] mreq,
  input logic [NM-1:0] mrdy,
  input logic [NM-1:0] mack,
  input logic [3:0]    xreq,
  input logic [3:0]    xgnt,
  input logic          excl,
  input logic          dram
);
  a_r3_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mack));

  a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mack == '0 && mreq != '0) |=> (mack == ($past(mreq) & (~$past(mreq) + NM'(1)))));

  a_r4_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    ((mack & mreq & ~mrdy) != '0) |=> $stable(mack));

  a_r5_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ((mack & (~mreq | mrdy)) != '0) |=> (mack == '0));

  a_r7_ext_excl: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(xgnt) <= 1) || (xgnt == 4'b1001 && !excl && !dram));

  a_r10_mst_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xgnt[3]) |-> $past(mack[NM-1:1] != '0));

  a_r11_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((xgnt & xreq) != '0) |=> ((xgnt & $past(xgnt & xreq)) == $past(xgnt & xreq)));
endmodule

bind busarb_top busarb_chk #(.NM(NM)) u_chk (
  .clk(clk), .rst_n(rst_n), .mreq(mreq), .mrdy(mrdy), .mack(mack),
  .xreq(xreq_eff), .xgnt(xgnt), .excl(rfsh_excl), .dram(mst_xdram)
);

// File: tb/sim_busarb_top.sv
module sim_busarb_top;
  localparam int CLK_PER = 10;
  localparam int NM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NM-1:0] mreq = '0, mrdy = '0, mack;
  logic rfsh_excl = 1'b0, rfsh_req = 1'b0, xdma_xreq = 1'b0, brel_req = 1'b0;
  logic mst_xreq = 1'b0, mst_xdram = 1'b0;
  logic rfsh_gnt, xdma_xgnt, brel_gnt, mst_xgnt;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model state
  bit m_vld = 0;
  int m_own = 0;
  logic [3:0] m_xg = '0;

  always #(CLK_PER/2) clk = ~clk;

  busarb_top #(.NM(NM)) u0 (
    .clk(clk), .rst_n(rst_n), .mreq(mreq), .mrdy(mrdy), .rfsh_excl(rfsh_excl),
    .rfsh_req(rfsh_req), .xdma_xreq(xdma_xreq), .brel_req(brel_req),
    .mst_xreq(mst_xreq), .mst_xdram(mst_xdram), .mack(mack),
    .rfsh_gnt(rfsh_gnt), .xdma_xgnt(xdma_xgnt), .brel_gnt(brel_gnt), .mst_xgnt(mst_xgnt)
  );

  function automatic logic [NM-1:0] exp_ack();
    logic [NM-1:0] a = '0;
    if (m_vld) a[m_own] = 1'b1;
    return a;
  endfunction

  // external grant set from rank order and sharing rule
  function automatic logic [3:0] exp_ext(logic [3:0] cur, logic [3:0] rq, logic ex, logic dr);
    logic [3:0] res = cur & rq;
    logic [3:0] keep = cur & rq;
    bit stopped = 0;
    for (int k = 0; k < 4; k++) begin
      if (rq[k] && !keep[k] && !stopped) begin
        bit ok = (res == 4'b0000) ||
                 (!ex && !dr && ((k == 0 && res == 4'b1000) || (k == 3 && res == 4'b0001)));
        if (ok) res[k] = 1'b1; else stopped = 1;
      end
    end
    return res;
  endfunction

  function automatic logic [3:0] got_ext();
    return {mst_xgnt, brel_gnt, xdma_xgnt, rfsh_gnt};
  endfunction

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model updates at the edge, outputs compared at the falling edge
  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      m_vld = 0; m_own = 0; m_xg = '0;
    end else begin
      logic [3:0] rq;
      rq = {mst_xreq && m_vld && m_own != 0, brel_req, xdma_xreq, rfsh_req};
      m_xg = exp_ext(m_xg, rq, rfsh_excl, mst_xdram);
      if (m_vld) begin
        if (!mreq[m_own] || mrdy[m_own]) m_vld = 0;
      end else if (mreq != '0) begin
        for (int i = NM - 1; i >= 0; i--) if (mreq[i]) m_own = i;
        m_vld = 1;
      end
    end
    @(negedge clk);
    chk(mack == exp_ack(), "R2 R4 R5 ack", 8'(mack), 8'(exp_ack()));
    chk(got_ext() == m_xg, "R6 R8 R9 R10 R11 xgnt", 8'(got_ext()), 8'(m_xg));
    chk($countones(mack) <= 1, "R3 one ack", 8'(mack), 8'(exp_ack()));
    if (!(rfsh_excl == 0 && mst_xdram == 0))
      chk($countones(got_ext()) <= 1, "R7 ext exclusive", 8'(got_ext()), 8'(m_xg));
  endtask

  task automatic idle_all();
    mreq = '0; mrdy = '0; rfsh_req = 0; xdma_xreq = 0; brel_req = 0; mst_xreq = 0;
    repeat (3) step();
  endtask

  task automatic drive_rand();
    for (int i = 0; i < NM; i++) begin
      if (!mreq[i]) mreq[i] = ($urandom % 5 == 0);
      else if (mack[i]) mreq[i] = !($urandom % 7 == 0);
      mrdy[i] = ($urandom % 9 == 0);
    end
    if (!rfsh_req) rfsh_req = ($urandom % 12 == 0); else rfsh_req = !($urandom % 4 == 0);
    if (!xdma_xreq) xdma_xreq = ($urandom % 10 == 0); else xdma_xreq = !($urandom % 5 == 0);
    if (!brel_req) brel_req = ($urandom % 14 == 0); else brel_req = !($urandom % 5 == 0);
    if (!mst_xreq) begin
      mst_xdram = ($urandom % 3 == 0);
      mst_xreq = ($urandom % 3 == 0);
    end else mst_xreq = !($urandom % 4 == 0);
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    step(); step();
    chk(mack == '0 && got_ext() == '0, "R1 reset", 8'({mack, got_ext()}), 8'd0);
    rst_n = 1;
    step();
    chk(mack == '0 && got_ext() == '0, "R1 after reset", 8'({mack, got_ext()}), 8'd0);

    // R2: data-transfer ctrl beats CPU
    mreq = 4'b1100; step();
    chk(mack == 4'b0100, "R2 priority", 8'(mack), 8'b0100);
    // R4: higher request does not preempt
    mreq = 4'b1101; step(); step();
    chk(mack == 4'b0100, "R4 no preempt", 8'(mack), 8'b0100);
    // R5: release strobe, one idle cycle, then DMA engine
    mrdy = 4'b0100; step(); mrdy = '0;
    chk(mack == 4'b0000, "R5 idle gap", 8'(mack), 8'b0000);
    step();
    chk(mack == 4'b0001, "R2 after gap", 8'(mack), 8'b0001);
    idle_all();

    // R8: shared mode, DMA controller owns, non-DRAM access plus refresh
    rfsh_excl = 0; mst_xdram = 0; mreq = 4'b0010; step(); step();
    mst_xreq = 1; step();
    chk(mst_xgnt == 1, "R10 mst granted with owner", 8'(mst_xgnt), 8'd1);
    rfsh_req = 1; step();
    chk(got_ext() == 4'b1001, "R8 refresh shares", 8'(got_ext()), 8'b1001);
    xdma_xreq = 1; rfsh_req = 0; step();
    chk(got_ext() == 4'b1000, "R6 xdma waits on held mst", 8'(got_ext()), 8'b1000);
    brel_req = 1; mst_xreq = 0; step();
    chk(got_ext() == 4'b0010, "R6 xdma before brel", 8'(got_ext()), 8'b0010);
    idle_all();

    // R9: exclusive mode
    rfsh_excl = 1; mreq = 4'b0100; step(); step();
    brel_req = 1; step();
    rfsh_req = 1; mst_xreq = 1; step(); step();
    chk(got_ext() == 4'b0100, "R9 refresh waits", 8'(got_ext()), 8'b0100);
    brel_req = 0; step();
    chk(got_ext() == 4'b0001, "R9 refresh alone", 8'(got_ext()), 8'b0001);
    step();
    chk(got_ext() == 4'b0001, "R11 refresh held", 8'(got_ext()), 8'b0001);
    mreq = 4'b0000; step();
    idle_all();

    for (int ph = 0; ph < 4; ph++) begin
      rfsh_excl = ph[0];
      for (int c = 0; c < 3000; c++) begin
        drive_rand();
        step();
      end
      idle_all();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule